// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the descriptor side of a network transmit path. Software places a ring of 16-byte transmit descriptors in memory and programs its location, its size in bytes and a tail index through a small write-only register port. The engine owns every descriptor from its head index up to, but not including, the tail. While transmit is enabled and head differs from tail, it reads the descriptor at the head as four 32-bit words from a word-addressed memory port. It then presents the buffer address, the packet length and the end-of-packet and insert-CRC command bits to a downstream frame-request interface.

After the frame request has been accepted, the engine sets the descriptor-done bit in the descriptor's status byte and writes that byte back to memory. It does this when the descriptor asks for a status report, or for every descriptor when descriptor granularity is selected. It then advances the head, wrapping to zero at the end of the ring. A self-clearing soft-reset bit returns the head, the tail and the sequencer to their idle state.

Descriptor word layout, little-endian within each word: word 0 holds buffer address bits 31:0, word 1 holds bits 63:32, word 2 holds the length in bits 15:0 and the command byte in bits 31:24, and word 3 holds the status byte in bits 7:0. The register port selects registers by `reg_addr`: 0 device control, 1 transmit control, 2 ring base, 3 ring length, 4 tail, 5 descriptor control.

Top module: `txring_engine`

## Requirements
- R1: After `rst_n` is released, `head_idx` and `tail_idx` are 0, `srst_busy` is 0, and neither `mem_req` nor `frame_valid` is asserted. The ring size is 8 descriptors.
- R2: While head differs from tail and transmit is enabled, the engine issues four reads, one at a time, at word addresses `{base[31:4] + head, k}` for k = 0, 1, 2, 3. Each read is accepted when `mem_req` and `mem_ready` are both high. `mem_rdata` holds the word exactly READ_LAT cycles after the accepting edge. The engine stays idle whenever head equals tail.
- R3: For each descriptor, `frame_valid` presents `frame_addr` = {word 1, word 0}, `frame_len` = word 2 bits 15:0, `frame_eop` = command bit 0 (word 2 bit 24) and `frame_ifcs` = command bit 1 (word 2 bit 25). All of these hold stable until `frame_ready` is seen.
- R4: When command bit 3 (report status, word 2 bit 27) is set, one write follows acceptance of the frame. It goes to word 3 of the same descriptor with `mem_wstrb` = 4'b0001 and carries the old word 3 with bit 0 (descriptor done) set. With that bit clear and granularity off, no write is issued.
- R5: Bit 24 of the descriptor control register (address 5) forces the status write-back of R4 for every descriptor, whatever its command bits.
- R6: The head advances by one after a descriptor completes: after frame acceptance, or after the write-back when one is due. It wraps to 0 when it reaches the ring size, which is the ring length register divided by 16.
- R7: A descriptor fetch only starts while bit 1 of the transmit control register (address 1) is set. With it clear, no read is issued and the head does not move.
- R8: A tail write (address 4) whose value is at or beyond the ring size leaves the tail unchanged. A ring length write (address 3) below 128 bytes, or above 16 * 2^IDX_W bytes, leaves the ring size unchanged.
- R9: Writing 1 to bit 26 of device control (address 0) raises `srst_busy` for RST_CYC cycles. During that time any descriptor in progress is abandoned, head and tail return to 0, and register writes are ignored. `srst_busy` then clears by itself.
- R10: No descriptor read is issued while a frame request is pending: the next descriptor is fetched only after the current one has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_wstrb | output | 4 | Memory byte strobes |
| mem_ready | input | 1 | Memory accepts request |
| mem_rdata | input | 32 | Memory read data, READ_LAT cycles after accept |
| frame_valid | output | 1 | Frame request valid |
| frame_ready | input | 1 | Frame request accepted |
| frame_addr | output | 64 | Packet buffer address |
| frame_len | output | 16 | Packet length in bytes |
| frame_eop | output | 1 | End of packet command |
| frame_ifcs | output | 1 | Insert frame checksum command |
| head_idx | output | IDX_W | Current head index |
| tail_idx | output | IDX_W | Current tail index |
| srst_busy | output | 1 | Soft reset in progress |

## Verification
The bench builds the engine with IDX_W = 6, READ_LAT = 3 and RST_CYC = 5. A read latency above one selects the counter-based capture path, so every descriptor spends several cycles waiting on returning words, and random back-pressure on both handshakes falls on every sequencer state. A six-bit index permits rings of 8 and 16 descriptors, so the head wraps many times within a short run. A short reset window lets the soft reset land on a descriptor held in its frame-request state and be checked to completion.

// File: rtl/txring_pkg.sv
package txring_pkg;

   // register select codes
   localparam logic [2:0] RA_DEVCTL  = 3'd0;
   localparam logic [2:0] RA_TXCTL   = 3'd1;
   localparam logic [2:0] RA_BASE    = 3'd2;
   localparam logic [2:0] RA_LEN     = 3'd3;
   localparam logic [2:0] RA_TAIL    = 3'd4;
   localparam logic [2:0] RA_DESCCTL = 3'd5;

   // control bit positions
   localparam int DEVCTL_SRST_BIT = 26;
   localparam int TXCTL_EN_BIT    = 1;
   localparam int DESCCTL_GRAN_BIT = 24;

   // command byte bits (byte 11 of a descriptor, word 2 bits 31:24)
   localparam int CMD_EOP  = 0;
   localparam int CMD_IFCS = 1;
   localparam int CMD_RS   = 3;

   // status byte bit (byte 12, word 2... word 3 bits 7:0)
   localparam int STA_DONE = 0;

   localparam int MIN_RING_BYTES = 128;
   localparam int DESC_BYTES     = 16;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_RD_REQ,
      SQ_RD_WAIT,
      SQ_FRAME,
      SQ_WBACK
   } seq_state_t;

endpackage

// File: rtl/txring_regs.sv
module txring_regs
   import txring_pkg::*;
#(
   parameter int IDX_W   = 8,
   parameter int MEM_AW  = 30,
   parameter int RST_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic              tx_en,
   output logic              gran,
   output logic [MEM_AW-3:0] base_hi,
   output logic [IDX_W:0]    ring_sz,
   output logic [IDX_W-1:0]  tail,
   output logic              srst
);

   localparam int RC_W      = $clog2(RST_CYC + 1);
   localparam int MAX_BYTES = DESC_BYTES << IDX_W;
   localparam int MIN_DESC  = MIN_RING_BYTES / DESC_BYTES;

   logic [RC_W-1:0] rst_cnt;
   logic            wr_ok;
   logic            len_ok;
   logic            tail_ok;

   assign srst    = (rst_cnt != '0);
   assign wr_ok   = reg_we && !srst;
   assign len_ok  = (reg_wdata >= 32'(MIN_RING_BYTES)) && (reg_wdata <= 32'(MAX_BYTES));
   assign tail_ok = reg_wdata < 32'(ring_sz);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rst_cnt <= '0;
      end else if (srst) begin
         rst_cnt <= rst_cnt - 1'b1;
      end else if (wr_ok && reg_addr == RA_DEVCTL && reg_wdata[DEVCTL_SRST_BIT]) begin
         rst_cnt <= RC_W'(RST_CYC);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_en   <= 1'b0;
         gran    <= 1'b0;
         base_hi <= '0;
         ring_sz <= (IDX_W+1)'(MIN_DESC);
      end else if (wr_ok) begin
         case (reg_addr)
            RA_TXCTL:   tx_en   <= reg_wdata[TXCTL_EN_BIT];
            RA_DESCCTL: gran    <= reg_wdata[DESCCTL_GRAN_BIT];
            RA_BASE:    base_hi <= reg_wdata[MEM_AW+1:4];
            RA_LEN:     if (len_ok) ring_sz <= reg_wdata[IDX_W+4:4];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || srst) begin
         tail <= '0;
      end else if (reg_we && reg_addr == RA_TAIL && tail_ok) begin
         tail <= reg_wdata[IDX_W-1:0];
      end
   end

   // R8: out-of-range tail writes leave the tail alone
   p_tail_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == RA_TAIL && !srst && reg_wdata >= 32'(ring_sz)) |=> $stable(tail));

   // R9: the reset window ends with the tail back at zero
   p_srst_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(srst) |-> tail == '0);

   // R8: ring size stays within the legal range
   p_ring_sz_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ring_sz >= (IDX_W+1)'(MIN_DESC));

endmodule

// File: rtl/txring_head.sv
module txring_head #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [IDX_W:0]   ring_sz,
   output logic [IDX_W-1:0] head
);

   logic [IDX_W:0] head_inc;

   assign head_inc = {1'b0, head} + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         head <= '0;
      end else if (adv) begin
         head <= (head_inc >= ring_sz) ? '0 : head_inc[IDX_W-1:0];
      end
   end

   // R6: head only moves when a descriptor completes
   p_head_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(head));

   // R9: soft reset returns head to zero
   p_head_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> head == '0);

endmodule

// File: rtl/txring_fetch.sv
module txring_fetch
   import txring_pkg::*;
#(
   parameter int IDX_W    = 8,
   parameter int MEM_AW   = 30,
   parameter int READ_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srst,
   input  logic              tx_en,
   input  logic              gran,
   input  logic [MEM_AW-3:0] base_hi,
   input  logic [IDX_W-1:0]  head,
   input  logic [IDX_W-1:0]  tail,
   output logic              adv,
   output logic              mem_req,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   output logic [3:0]        mem_wstrb,
   input  logic              mem_ready,
   input  logic [31:0]       mem_rdata,
   output logic              frame_valid,
   input  logic              frame_ready,
   output logic [63:0]       frame_addr,
   output logic [15:0]       frame_len,
   output logic              frame_eop,
   output logic              frame_ifcs
);

   localparam int CW = $clog2(READ_LAT + 1);

   seq_state_t        st;
   logic [1:0]        wsel;
   logic [31:0]       dw [4];
   logic              lat_hit;
   logic              go;
   logic              wb_due;
   logic [MEM_AW-3:0] desc_base;

   assign go        = tx_en && (head != tail);
   assign wb_due    = dw[2][24 + CMD_RS] || gran;
   assign desc_base = base_hi + (MEM_AW-2)'(head);

   generate
      if (READ_LAT == 1) begin : g_lat1
         assign lat_hit = 1'b1;
      end else begin : g_latn
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (st == SQ_RD_REQ && mem_ready) begin
               cnt <= CW'(1);
            end else if (st == SQ_RD_WAIT && !lat_hit) begin
               cnt <= cnt + 1'b1;
            end
         end
         assign lat_hit = (cnt == CW'(READ_LAT));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || srst) begin
         st   <= SQ_IDLE;
         wsel <= '0;
      end else begin
         case (st)
            SQ_IDLE: begin
               wsel <= '0;
               if (go) st <= SQ_RD_REQ;
            end
            SQ_RD_REQ: if (mem_ready) st <= SQ_RD_WAIT;
            SQ_RD_WAIT: begin
               if (lat_hit) begin
                  wsel <= wsel + 1'b1;
                  st   <= (wsel == 2'd3) ? SQ_FRAME : SQ_RD_REQ;
               end
            end
            SQ_FRAME: if (frame_ready) st <= wb_due ? SQ_WBACK : SQ_IDLE;
            SQ_WBACK: if (mem_ready) st <= SQ_IDLE;
            default:  st <= SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (st == SQ_RD_WAIT && lat_hit) begin
         dw[wsel] <= mem_rdata;
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = {desc_base, wsel};
      mem_wdata = '0;
      mem_wstrb = 4'b0000;
      adv       = 1'b0;
      case (st)
         SQ_RD_REQ: mem_req = 1'b1;
         SQ_FRAME:  adv = frame_ready && !wb_due;
         SQ_WBACK: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {desc_base, 2'd3};
            mem_wdata = dw[3] | (32'd1 << STA_DONE);
            mem_wstrb = 4'b0001;
            adv       = mem_ready;
         end
         default: ;
      endcase
   end

   assign frame_valid = (st == SQ_FRAME);
   assign frame_addr  = {dw[1], dw[0]};
   assign frame_len   = dw[2][15:0];
   assign frame_eop   = dw[2][24 + CMD_EOP];
   assign frame_ifcs  = dw[2][24 + CMD_IFCS];

   // R3: a pending frame request holds its contents
   p_frame_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || srst)
      (frame_valid && !frame_ready) |=> frame_valid && $stable(frame_addr)
         && $stable(frame_len) && $stable(frame_eop) && $stable(frame_ifcs));

   // R4: write-back touches only the status byte of word 3 and marks done
   p_wb_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wstrb == 4'b0001 && mem_wdata[STA_DONE] && mem_addr[1:0] == 2'd3);

   // R10: no descriptor read while a frame request waits
   p_no_read_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> !(mem_req && !mem_we));

   // R7: a disabled engine stays idle
   p_disabled_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_IDLE && !tx_en) |=> st == SQ_IDLE);

   // R2: an empty ring keeps the engine idle
   p_empty_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_IDLE && head == tail) |=> st == SQ_IDLE);

endmodule

// File: rtl/txring_engine.sv
module txring_engine #(
   parameter int IDX_W    = 8,
   parameter int MEM_AW   = 30,
   parameter int READ_LAT = 2,
   parameter int RST_CYC  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   output logic [3:0]        mem_wstrb,
   input  logic              mem_ready,
   input  logic [31:0]       mem_rdata,
   output logic              frame_valid,
   input  logic              frame_ready,
   output logic [63:0]       frame_addr,
   output logic [15:0]       frame_len,
   output logic              frame_eop,
   output logic              frame_ifcs,
   output logic [IDX_W-1:0]  head_idx,
   output logic [IDX_W-1:0]  tail_idx,
   output logic              srst_busy
);

   if (IDX_W < 3 || IDX_W > 20) begin : g_bad_idx
      $error("txring_engine: IDX_W out of range");
   end
   if (MEM_AW < IDX_W + 2 || MEM_AW > 30) begin : g_bad_aw
      $error("txring_engine: MEM_AW out of range");
   end
   if (READ_LAT < 1) begin : g_bad_lat
      $error("txring_engine: READ_LAT must be at least 1");
   end
   if (RST_CYC <= READ_LAT) begin : g_bad_rst
      $error("txring_engine: RST_CYC must exceed READ_LAT");
   end

   logic              tx_en;
   logic              gran;
   logic [MEM_AW-3:0] base_hi;
   logic [IDX_W:0]    ring_sz;
   logic              adv;

   txring_regs #(
      .IDX_W   (IDX_W),
      .MEM_AW  (MEM_AW),
      .RST_CYC (RST_CYC)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .tx_en     (tx_en),
      .gran      (gran),
      .base_hi   (base_hi),
      .ring_sz   (ring_sz),
      .tail      (tail_idx),
      .srst      (srst_busy)
   );

   txring_head #(
      .IDX_W (IDX_W)
   ) u_head (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (srst_busy),
      .adv     (adv),
      .ring_sz (ring_sz),
      .head    (head_idx)
   );

   txring_fetch #(
      .IDX_W    (IDX_W),
      .MEM_AW   (MEM_AW),
      .READ_LAT (READ_LAT)
   ) u_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .srst        (srst_busy),
      .tx_en       (tx_en),
      .gran        (gran),
      .base_hi     (base_hi),
      .head        (head_idx),
      .tail        (tail_idx),
      .adv         (adv),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_wstrb   (mem_wstrb),
      .mem_ready   (mem_ready),
      .mem_rdata   (mem_rdata),
      .frame_valid (frame_valid),
      .frame_ready (frame_ready),
      .frame_addr  (frame_addr),
      .frame_len   (frame_len),
      .frame_eop   (frame_eop),
      .frame_ifcs  (frame_ifcs)
   );

endmodule

// File: tb/txring_engine_bench.sv
`timescale 1ns/1ps
module txring_engine_bench;

   localparam int IDX_W    = 6;
   localparam int MEM_AW   = 30;
   localparam int READ_LAT = 3;
   localparam int RST_CYC  = 5;
   localparam int BASE_W   = 32;   // ring base, word address (byte 128)

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_we = 1'b0;
   logic [2:0]        reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic              mem_req, mem_we;
   logic [MEM_AW-1:0] mem_addr;
   logic [31:0]       mem_wdata;
   logic [3:0]        mem_wstrb;
   logic              mem_ready = 1'b0;
   logic [31:0]       mem_rdata = '0;
   logic              frame_valid;
   logic              frame_ready = 1'b0;
   logic [63:0]       frame_addr;
   logic [15:0]       frame_len;
   logic              frame_eop, frame_ifcs;
   logic [IDX_W-1:0]  head_idx, tail_idx;
   logic              srst_busy;

   txring_engine #(
      .IDX_W(IDX_W), .MEM_AW(MEM_AW), .READ_LAT(READ_LAT), .RST_CYC(RST_CYC)
   ) u_txring_engine (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_wstrb(mem_wstrb), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .frame_valid(frame_valid), .frame_ready(frame_ready), .frame_addr(frame_addr),
      .frame_len(frame_len), .frame_eop(frame_eop), .frame_ifcs(frame_ifcs),
      .head_idx(head_idx), .tail_idx(tail_idx), .srst_busy(srst_busy)
   );

   always #4 clk = ~clk;   // 125 MHz

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [31:0] mem [0:255];
   int          pipe [0:READ_LAT];
   int          exp_head = 0;
   int          exp_sz = 8;
   bit          gran_b = 1'b0;
   bit          hold_frame = 1'b0;
   bit          pend_wb = 1'b0;
   int          rd_cnt = 0;
   int          fr_cnt = 0;
   int          wb_cnt = 0;
   int          exp_wb = 0;
   int          rd_k = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int dbase(input int h);
      return BASE_W + h * 4;
   endfunction

   function automatic int next_idx(input int h);
      return (h + 1 >= exp_sz) ? 0 : h + 1;
   endfunction

   // memory and frame-side model, all at the falling edge
   always @(negedge clk) begin
      bit fr, mr;
      cycles++;
      fr = !hold_frame && ($urandom % 4 != 0);
      mr = ($urandom % 3 != 0);
      if (!rst_n || srst_busy) begin
         fr = 1'b0; mr = 1'b0;
         if (srst_busy) begin exp_head = 0; pend_wb = 1'b0; rd_k = 0; end
      end
      frame_ready = fr;
      mem_ready   = mr;
      for (int i = READ_LAT; i > 0; i--) pipe[i] = pipe[i-1];
      pipe[0] = -1;
      if (frame_valid && fr) begin
         int b;
         logic [31:0] w2;
         b  = dbase(exp_head);
         w2 = mem[b+2];
         fr_cnt++;
         chk(frame_addr == {mem[b+1], mem[b]}, "R3 addr", frame_addr, {mem[b+1], mem[b]});
         chk(frame_len == w2[15:0] && frame_eop == w2[24] && frame_ifcs == w2[25],
             "R3 len/cmd", {frame_len, frame_eop, frame_ifcs}, {w2[15:0], w2[24], w2[25]});
         if (w2[27] || gran_b) begin
            pend_wb = 1'b1; exp_wb++;
         end else begin
            exp_head = next_idx(exp_head);
         end
      end
      if (mem_req && mr) begin
         if (mem_we) begin
            int b;
            b = dbase(exp_head);
            wb_cnt++;
            chk(pend_wb, "R4 unexpected write", 0, 1);
            chk(int'(mem_addr) == b + 3 && mem_wstrb == 4'b0001 && mem_wdata == (mem[b+3] | 32'd1),
                "R4 write", mem_wdata, mem[b+3] | 32'd1);
            mem[b+3][7:0] = mem_wdata[7:0];
            pend_wb = 1'b0;
            exp_head = next_idx(exp_head);
         end else begin
            rd_cnt++;
            chk(int'(mem_addr) == dbase(exp_head) + rd_k, "R2 read addr", mem_addr, dbase(exp_head) + rd_k);
            chk(!frame_valid, "R10 read while frame pending", 1, 0);
            rd_k = (rd_k + 1) % 4;
            pipe[0] = int'(mem_addr[7:0]);
         end
      end
      mem_rdata = (pipe[READ_LAT] >= 0) ? mem[pipe[READ_LAT]] : 32'hDEAD_BEEF;
      if (cycles > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic wreg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   // rs_mode: 0 none, 1 all, 2 random
   task automatic fill_ring(input int rs_mode);
      for (int i = 0; i < exp_sz; i++) begin
         int b;
         logic [31:0] w2;
         b = dbase(i);
         mem[b]   = $urandom;
         mem[b+1] = $urandom;
         w2 = $urandom;
         w2[27] = (rs_mode == 1) ? 1'b1 : (rs_mode == 0) ? 1'b0 : w2[27];
         mem[b+2] = w2;
         mem[b+3] = $urandom & 32'hFFFF_FF00;
      end
   endtask

   task automatic run_to(input int t, input string req);
      int n0, w0, wexp0, want;
      n0 = fr_cnt; w0 = wb_cnt; wexp0 = exp_wb;
      want = (t - exp_head + exp_sz) % exp_sz;
      wreg(3'd4, t);
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (head_idx == tail_idx && !frame_valid && !mem_req) break;
      end
      chk(int'(head_idx) == t && int'(head_idx) == exp_head, {req, " head"}, head_idx, t);
      chk(fr_cnt - n0 == want, {req, " frames"}, fr_cnt - n0, want);
      chk(wb_cnt - w0 == exp_wb - wexp0 && !pend_wb, {req, " writebacks"}, wb_cnt - w0, exp_wb - wexp0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      for (int i = 0; i <= READ_LAT; i++) pipe[i] = -1;
      void'($urandom(32'd5150));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(head_idx == 0 && tail_idx == 0, "R1 pointers", {head_idx, tail_idx}, 0);
      chk(!mem_req && !frame_valid && !srst_busy, "R1 outputs", {mem_req, frame_valid, srst_busy}, 0);

      wreg(3'd2, 32'd128);          // base byte address 128 -> word 32
      wreg(3'd3, 32'd128);
      fill_ring(2);
      // R7 disabled: tail moves, nothing fetched
      wreg(3'd4, 32'd5);
      repeat (40) @(negedge clk);
      chk(rd_cnt == 0 && head_idx == 0, "R7 disabled no fetch", rd_cnt, 0);
      wreg(3'd1, 32'h2);            // enable
      run_to(5, "R2/R3/R4 first batch");

      // R8 tail at ring size ignored; short length ignored
      wreg(3'd4, 32'd8);
      chk(tail_idx == 5, "R8 tail out of range", tail_idx, 5);
      wreg(3'd3, 32'd64);
      wreg(3'd4, 32'd300);
      chk(tail_idx == 5, "R8 tail far out of range", tail_idx, 5);
      run_to(7, "R8 length kept");
      run_to(3, "R6 wrap");

      // R5 granularity forces write-back
      gran_b = 1'b1;
      wreg(3'd5, 32'h0100_0000);
      fill_ring(0);
      begin
         int w0;
         w0 = wb_cnt;
         run_to(1, "R5 granularity");
         chk(wb_cnt - w0 == 6, "R5 all written back", wb_cnt - w0, 6);
      end
      gran_b = 1'b0;
      wreg(3'd5, 32'h0);
      begin
         int w0;
         w0 = wb_cnt;
         run_to(6, "R4 no report");
         chk(wb_cnt == w0, "R4 no write without RS", wb_cnt - w0, 0);
      end

      // larger ring, random rounds
      wreg(3'd3, 32'd256);
      exp_sz = 16;
      for (int r = 0; r < 12; r++) begin
         gran_b = ($urandom % 3 == 0);
         wreg(3'd5, gran_b ? 32'h0100_0000 : 32'h0);
         fill_ring(2);
         run_to($urandom % 16, "R6 random round");
      end

      // R9 soft reset with a frame held
      hold_frame = 1'b1;
      wreg(3'd4, (exp_head + 2) % exp_sz);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (frame_valid) break;
      end
      chk(frame_valid, "R9 frame held", frame_valid, 1);
      wreg(3'd0, 32'h0400_0000);
      chk(srst_busy, "R9 busy raised", srst_busy, 1);
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (!srst_busy) break;
      end
      hold_frame = 1'b0;
      chk(!srst_busy && head_idx == 0 && tail_idx == 0 && !frame_valid,
          "R9 cleared", {srst_busy, head_idx, tail_idx, frame_valid}, 0);
      run_to(3, "R9 resume");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule